// File: doc/BRIEF.md
# SMBus Banked Memory Slave

This block is a two-wire serial slave that gives a bus master access to two byte-wide storage banks of 1024 locations each. One bank is the nonvolatile-style array and the other holds RAM and registers. It runs on a fast system clock and oversamples the open-drain clock and data lines. It never drives the clock line. On the data line it only pulls low, for acknowledges and for read data.

A write transfer carries the slave address, then a control byte and a low-address byte. The control byte holds a block flag, a bank selector and the two upper address bits. In block mode a byte count follows. Then come the data bytes, and an optional CRC-8 check byte may close the frame. Write data is held in a small buffer and written to the bank only when the transfer ends. A failed check byte therefore discards the whole write. Reads use a short write that sets the pointer, a repeated START and the address with the read bit set. The slave then streams bytes until the master declines one.

Top module: `smb_banked_slave`

## Requirements
- R1: After reset the slave does not pull the data line low. The clock line is an input only.
- R2: An address byte whose upper seven bits equal SLV_ADDR (default 0x2C) is acknowledged. Any other address is not acknowledged, and every byte up to the next START or STOP is ignored and left unacknowledged.
- R3: The control byte holds the block flag in bit 7, the bank code in bits 3:2 and address bits 9:8 in bits 1:0. Bits 6:4 have no effect. A low-address byte with address bits 7:0 follows it, and both bytes are acknowledged.
- R4: Bank code 00 selects the nonvolatile array and 01 selects the RAM bank. The two banks are separate storage. Codes 10 and 11 are not acknowledged at the control byte.
- R5: With the block flag clear, exactly one data byte follows the low-address byte. With the flag set, a count byte follows it, and that many data bytes come next. A count of 0 or above MAX_BLK (default 8) is not acknowledged.
- R6: The byte after the last data byte is a check byte. It is compared with a CRC-8 (polynomial 0x07, initial value 0, data MSB first) taken over every earlier byte of the transfer, starting with the address byte. On a match it is acknowledged. On a mismatch it is not acknowledged and the buffered write is dropped.
- R7: A write takes effect when the transfer ends with a STOP or a repeated START. Its bytes go to consecutive addresses, and 0x3FF wraps to 0x000 inside the same bank.
- R8: An address byte with the direction bit set is acknowledged. The slave then sends bytes MSB first from the bank and address set by the last control and low-address bytes. The address advances after each byte the master acknowledges and wraps like writes. After the master declines a byte, the slave releases the data line.
- R9: A repeated START ends the current transfer and restarts address recognition without a STOP in between.
- R10: The slave changes its data-line drive only while the clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | When high, the pad pulls the data line low |

## Verification
Each change on a bus line reaches the slave's logic through a two-stage synchronizer and an edge register. A new data-line drive therefore appears three system clocks after the clock-line edge that caused it. The bench keeps every bus phase eight clocks long and reads acknowledges and read data in the middle of the clock-high phase, well after that drive has settled. A write commit starts on the clock after the STOP or repeated START is detected and takes one clock per byte. Every read-back happens a full byte time or more later. One monitor flags any change of the drive while the master holds the clock high.

// File: rtl/smb_slave_pkg.sv
`timescale 1ns/1ps
package smb_slave_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 10;
  localparam int BANK_W = 2;
  localparam int LIVE_BANKS = 2;

  typedef enum logic [2:0] {
    F_ADDR, F_CTRL, F_ALO, F_CNT, F_DATA, F_PEC, F_DONE, F_TX
  } frame_st_t;

  typedef enum logic [2:0] {
    L_IDLE, L_RX, L_RXW, L_ACK, L_TX, L_MACK, L_MACKW, L_HOLD
  } link_st_t;

  // one CRC-8 update, polynomial x^8+x^2+x+1, byte folded in at once
  function automatic logic [7:0] crc8_step(input logic [7:0] crc, input logic [7:0] d);
    logic [7:0] c;
    c = crc ^ d;
    for (int i = 0; i < 8; i++) begin
      c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
    end
    return c;
  endfunction

  function automatic logic [ADDR_W-1:0] addr_next(input logic [ADDR_W-1:0] a);
    return a + 1'b1;
  endfunction
endpackage

// File: rtl/smb_line_mon.sv
`timescale 1ns/1ps
module smb_line_mon #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
      scl_q    <= scl_s;
      sda_q    <= sda_s;
    end
  end

  assign scl_s    = scl_pipe[SYNC_STAGES-1];
  assign sda_s    = sda_pipe[SYNC_STAGES-1];
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/smb_link.sv
`timescale 1ns/1ps
module smb_link
  import smb_slave_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic              ack_req,
  input  logic              tx_mode,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic              sda_oe,
  output logic              rx_valid,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              mack,
  output logic              mnack
);
  link_st_t          st;
  logic [2:0]        bit_cnt;
  logic [BYTE_W-1:0] sh;

  assign rx_byte = sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= L_IDLE;
      bit_cnt  <= '0;
      sh       <= '0;
      sda_oe   <= 1'b0;
      rx_valid <= 1'b0;
      mack     <= 1'b0;
      mnack    <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      mack     <= 1'b0;
      mnack    <= 1'b0;
      if (start_ev) begin
        st      <= L_RX;
        bit_cnt <= '0;
        sda_oe  <= 1'b0;
      end else if (stop_ev) begin
        st     <= L_IDLE;
        sda_oe <= 1'b0;
      end else begin
        unique case (st)
          L_RX: if (scl_rise) begin
            sh      <= {sh[BYTE_W-2:0], sda_s};
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == 3'd7) begin
              rx_valid <= 1'b1;
              st       <= L_RXW;
            end
          end
          L_RXW: if (scl_fall) begin
            if (ack_req) begin
              sda_oe <= 1'b1;
              st     <= L_ACK;
            end else begin
              st <= L_HOLD;
            end
          end
          L_ACK: if (scl_fall) begin
            bit_cnt <= '0;
            if (tx_mode) begin
              sh     <= tx_byte;
              sda_oe <= ~tx_byte[BYTE_W-1];
              st     <= L_TX;
            end else begin
              sda_oe <= 1'b0;
              st     <= L_RX;
            end
          end
          L_TX: if (scl_fall) begin
            if (bit_cnt == 3'd7) begin
              sda_oe <= 1'b0;
              st     <= L_MACK;
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
              sh      <= sh << 1;
              sda_oe  <= ~sh[BYTE_W-2];
            end
          end
          L_MACK: if (scl_rise) begin
            if (!sda_s) begin
              mack <= 1'b1;
              st   <= L_MACKW;
            end else begin
              mnack <= 1'b1;
              st    <= L_HOLD;
            end
          end
          L_MACKW: if (scl_fall) begin
            bit_cnt <= '0;
            sh      <= tx_byte;
            sda_oe  <= ~tx_byte[BYTE_W-1];
            st      <= L_TX;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/smb_frame.sv
`timescale 1ns/1ps
module smb_frame
  import smb_slave_pkg::*;
#(
  parameter logic [6:0] SLV_ADDR = 7'h2C,
  parameter int MAX_BLK = 8,
  localparam int CNT_W = $clog2(MAX_BLK + 1),
  localparam int IDX_W = (MAX_BLK > 1) ? $clog2(MAX_BLK) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start_ev,
  input  logic                           stop_ev,
  input  logic                           rx_valid,
  input  logic [BYTE_W-1:0]              rx_byte,
  input  logic                           mack,
  output logic                           ack_req,
  output logic                           tx_mode,
  output logic [BANK_W-1:0]              ptr_bank,
  output logic [ADDR_W-1:0]              ptr_addr,
  output logic                           commit_go,
  output logic [BANK_W-1:0]              wr_bank,
  output logic [ADDR_W-1:0]              wr_base,
  output logic [CNT_W-1:0]               wr_count,
  output logic [MAX_BLK-1:0][BYTE_W-1:0] wr_data,
  output logic                           pec_bad,
  output logic                           reserved_hit
);
  frame_st_t         st;
  logic [7:0]        crc;
  logic              cur_bt;
  logic [BANK_W-1:0] cur_bank;
  logic [1:0]        cur_hi;
  logic [CNT_W-1:0]  idx;
  logic              have_data;

  // control-byte field views
  logic              c_bt;
  logic [BANK_W-1:0] c_bank;
  logic [1:0]        c_hi;
  logic              cnt_bad;
  assign c_bt    = rx_byte[7];
  assign c_bank  = rx_byte[3:2];
  assign c_hi    = rx_byte[1:0];
  assign cnt_bad = (rx_byte == 8'd0) || (rx_byte > 8'(MAX_BLK));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= F_DONE;
      crc          <= '0;
      cur_bt       <= 1'b0;
      cur_bank     <= '0;
      cur_hi       <= '0;
      idx          <= '0;
      have_data    <= 1'b0;
      ack_req      <= 1'b0;
      tx_mode      <= 1'b0;
      ptr_bank     <= '0;
      ptr_addr     <= '0;
      commit_go    <= 1'b0;
      wr_bank      <= '0;
      wr_base      <= '0;
      wr_count     <= '0;
      wr_data      <= '0;
      pec_bad      <= 1'b0;
      reserved_hit <= 1'b0;
    end else begin
      commit_go    <= 1'b0;
      pec_bad      <= 1'b0;
      reserved_hit <= 1'b0;
      if (start_ev || stop_ev) begin
        commit_go <= have_data;
        have_data <= 1'b0;
        st        <= start_ev ? F_ADDR : F_DONE;
        crc       <= '0;
        idx       <= '0;
        ack_req   <= 1'b0;
        tx_mode   <= 1'b0;
      end else if (rx_valid) begin
        if (st != F_PEC) crc <= crc8_step(crc, rx_byte);
        ack_req <= 1'b0;
        unique case (st)
          F_ADDR: begin
            if (rx_byte[7:1] == SLV_ADDR) begin
              ack_req <= 1'b1;
              if (rx_byte[0]) begin
                tx_mode <= 1'b1;
                st      <= F_TX;
              end else begin
                st <= F_CTRL;
              end
            end else begin
              st <= F_DONE;
            end
          end
          F_CTRL: begin
            if (c_bank[1]) begin
              reserved_hit <= 1'b1;
              st           <= F_DONE;
            end else begin
              ack_req  <= 1'b1;
              cur_bt   <= c_bt;
              cur_bank <= c_bank;
              cur_hi   <= c_hi;
              st       <= F_ALO;
            end
          end
          F_ALO: begin
            ack_req  <= 1'b1;
            ptr_bank <= cur_bank;
            ptr_addr <= {cur_hi, rx_byte};
            wr_bank  <= cur_bank;
            wr_base  <= {cur_hi, rx_byte};
            if (cur_bt) begin
              st <= F_CNT;
            end else begin
              wr_count <= CNT_W'(1);
              st       <= F_DATA;
            end
          end
          F_CNT: begin
            if (cnt_bad) begin
              st <= F_DONE;
            end else begin
              ack_req  <= 1'b1;
              wr_count <= rx_byte[CNT_W-1:0];
              st       <= F_DATA;
            end
          end
          F_DATA: begin
            ack_req               <= 1'b1;
            wr_data[idx[IDX_W-1:0]] <= rx_byte;
            idx                   <= idx + 1'b1;
            if (idx == wr_count - 1'b1) begin
              have_data <= 1'b1;
              st        <= F_PEC;
            end
          end
          F_PEC: begin
            st <= F_DONE;
            if (rx_byte == crc) begin
              ack_req <= 1'b1;
            end else begin
              have_data <= 1'b0;
              pec_bad   <= 1'b1;
            end
          end
          default: ;
        endcase
      end else if (mack && st == F_TX) begin
        ptr_addr <= addr_next(ptr_addr);
      end
    end
  end
endmodule

// File: rtl/smb_bank_store.sv
`timescale 1ns/1ps
module smb_bank_store
  import smb_slave_pkg::*;
#(
  parameter int MAX_BLK = 8,
  localparam int CNT_W = $clog2(MAX_BLK + 1),
  localparam int IDX_W = (MAX_BLK > 1) ? $clog2(MAX_BLK) : 1,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           commit_go,
  input  logic [BANK_W-1:0]              wr_bank,
  input  logic [ADDR_W-1:0]              wr_base,
  input  logic [CNT_W-1:0]               wr_count,
  input  logic [MAX_BLK-1:0][BYTE_W-1:0] wr_data,
  input  logic [BANK_W-1:0]              rd_bank,
  input  logic [ADDR_W-1:0]              rd_addr,
  output logic [BYTE_W-1:0]              rd_data,
  output logic                           wr_fire,
  output logic [ADDR_W-1:0]              wr_addr
);
  logic              busy;
  logic [CNT_W-1:0]  k;
  logic [BYTE_W-1:0] wr_byte;
  logic [BYTE_W-1:0] bank_q [LIVE_BANKS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      k    <= '0;
    end else if (commit_go) begin
      busy <= 1'b1;
      k    <= '0;
    end else if (busy) begin
      k <= k + 1'b1;
      if (k == wr_count - 1'b1) busy <= 1'b0;
    end
  end

  assign wr_fire = busy;
  assign wr_addr = wr_base + ADDR_W'(k);
  assign wr_byte = wr_data[k[IDX_W-1:0]];

  for (genvar g = 0; g < LIVE_BANKS; g++) begin : g_bank
    logic [BYTE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (wr_fire && wr_bank == BANK_W'(g)) mem[wr_addr] <= wr_byte;
    end
    assign bank_q[g] = mem[rd_addr];
  end

  always_comb begin
    rd_data = '0;
    for (int g = 0; g < LIVE_BANKS; g++) begin
      if (rd_bank == BANK_W'(g)) rd_data = bank_q[g];
    end
  end
endmodule

// File: rtl/smb_banked_slave.sv
`timescale 1ns/1ps
module smb_banked_slave
  import smb_slave_pkg::*;
#(
  parameter logic [6:0] SLV_ADDR = 7'h2C,
  parameter int MAX_BLK = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  localparam int CNT_W = $clog2(MAX_BLK + 1);

  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic ack_req, tx_mode, rx_valid, mack, mnack;
  logic [BYTE_W-1:0] rx_byte, tx_byte;
  logic [BANK_W-1:0] ptr_bank, wr_bank;
  logic [ADDR_W-1:0] ptr_addr, wr_base, wr_addr;
  logic [CNT_W-1:0]  wr_count;
  logic [MAX_BLK-1:0][BYTE_W-1:0] wr_data;
  logic commit_go, pec_bad, reserved_hit, wr_fire;

  smb_line_mon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  smb_link u_link (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev),
    .ack_req(ack_req), .tx_mode(tx_mode), .tx_byte(tx_byte),
    .sda_oe(sda_oe), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .mack(mack), .mnack(mnack)
  );

  smb_frame #(.SLV_ADDR(SLV_ADDR), .MAX_BLK(MAX_BLK)) u_frame (
    .clk(clk), .rst_n(rst_n), .start_ev(start_ev), .stop_ev(stop_ev),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .mack(mack),
    .ack_req(ack_req), .tx_mode(tx_mode), .ptr_bank(ptr_bank),
    .ptr_addr(ptr_addr), .commit_go(commit_go), .wr_bank(wr_bank),
    .wr_base(wr_base), .wr_count(wr_count), .wr_data(wr_data),
    .pec_bad(pec_bad), .reserved_hit(reserved_hit)
  );

  smb_bank_store #(.MAX_BLK(MAX_BLK)) u_store (
    .clk(clk), .rst_n(rst_n), .commit_go(commit_go), .wr_bank(wr_bank),
    .wr_base(wr_base), .wr_count(wr_count), .wr_data(wr_data),
    .rd_bank(ptr_bank), .rd_addr(ptr_addr), .rd_data(tx_byte),
    .wr_fire(wr_fire), .wr_addr(wr_addr)
  );
endmodule

// File: rtl/smb_banked_slave_chk.sv
`timescale 1ns/1ps
module smb_banked_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       sda_oe,
  input logic       start_ev,
  input logic       mnack,
  input logic       ack_req,
  input logic       pec_bad,
  input logic       reserved_hit,
  input logic       wr_fire,
  input logic [9:0] wr_addr
);
  // R10: a new pull-down only ever starts while the clock line is low
  a_r10_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  // R8: master decline releases the data line
  a_r8_release_after_nack: assert property (@(posedge clk) disable iff (!rst_n)
    mnack |=> !sda_oe);

  // R9: any START, repeated or not, leaves the line released and no ack pending
  a_r9_start_resets: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (!sda_oe && !ack_req));

  // R4: reserved bank code leaves no acknowledge pending
  a_r4_reserved_nack: assert property (@(posedge clk) disable iff (!rst_n)
    reserved_hit |-> !ack_req);

  // R6: check-byte mismatch leaves no acknowledge pending
  a_r6_pec_bad_nack: assert property (@(posedge clk) disable iff (!rst_n)
    pec_bad |-> !ack_req);

  // R7: commit writes step by one address with wrap
  a_r7_commit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && $past(wr_fire)) |-> (wr_addr == $past(wr_addr) + 10'd1));
endmodule

bind smb_banked_slave smb_banked_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe),
  .start_ev(start_ev), .mnack(mnack), .ack_req(ack_req),
  .pec_bad(pec_bad), .reserved_hit(reserved_hit),
  .wr_fire(wr_fire), .wr_addr(wr_addr)
);

// File: tb/sim_smb_banked_slave.sv
`timescale 1ns/1ps
module sim_smb_banked_slave;
  localparam int Q = 8;
  localparam logic [7:0] AW = 8'h58;
  localparam logic [7:0] AR = 8'h59;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda_low = 1'b0;
  logic sda_oe;
  wire  sda_line = ~(m_sda_low | sda_oe);

  int nchk = 0;
  int nfail = 0;
  int viol = 0;
  logic prev_oe = 1'b0;
  logic [7:0] wbuf [16];
  logic [7:0] rbuf [16];

  always #2.5 clk = ~clk;

  smb_banked_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe)
  );

  // R10 monitor: drive must not move while the master holds the clock high
  always @(negedge clk) begin
    if (rst_n && sda_oe !== prev_oe && m_scl) viol++;
    prev_oe <= sda_oe;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  function automatic logic [7:0] bcrc(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    logic fb;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      fb = r[7] ^ d[i];
      r  = {r[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
    end
    return r;
  endfunction

  task automatic bus_start();
    m_sda_low = 1'b0; m_scl = 1'b1; wq();
    m_sda_low = 1'b1; wq();
    m_scl = 1'b0; wq();
  endtask

  task automatic bus_rstart();
    m_sda_low = 1'b0; wq();
    m_scl = 1'b1; wq();
    m_sda_low = 1'b1; wq();
    m_scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    m_sda_low = 1'b1; wq();
    m_scl = 1'b1; wq();
    m_sda_low = 1'b0; wq(); wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda_low = ~b[i]; wq();
      m_scl = 1'b1; wq(); wq();
      m_scl = 1'b0; wq();
    end
    m_sda_low = 1'b0; wq();
    m_scl = 1'b1; wq();
    ack = ~sda_line;
    wq();
    m_scl = 1'b0; wq();
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    m_sda_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      wq();
      m_scl = 1'b1; wq();
      b[i] = sda_line;
      wq();
      m_scl = 1'b0;
    end
    wq();
    m_sda_low = give_ack;
    wq();
    m_scl = 1'b1; wq(); wq();
    m_scl = 1'b0; wq();
    m_sda_low = 1'b0;
  endtask

  // write transfer; pec_mode 0 none, 1 correct, 2 corrupted
  task automatic wr_xfer(input logic [1:0] bank, input logic [9:0] a, input bit bt,
                         input int n, input int pec_mode, input logic [2:0] junk,
                         input bit end_stop, output bit all_ack, output bit pec_ack);
    logic [7:0] c, ctrl;
    bit ak;
    c = 8'h00;
    all_ack = 1'b1;
    pec_ack = 1'b0;
    ctrl = {bt, junk, bank, a[9:8]};
    bus_start();
    send_byte(AW, ak);        all_ack &= ak; c = bcrc(c, AW);
    send_byte(ctrl, ak);      all_ack &= ak; c = bcrc(c, ctrl);
    send_byte(a[7:0], ak);    all_ack &= ak; c = bcrc(c, a[7:0]);
    if (bt) begin
      send_byte(8'(n), ak);   all_ack &= ak; c = bcrc(c, 8'(n));
    end
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], ak); all_ack &= ak; c = bcrc(c, wbuf[i]);
    end
    if (pec_mode == 1) send_byte(c, pec_ack);
    if (pec_mode == 2) send_byte(c ^ 8'h5A, pec_ack);
    if (end_stop) bus_stop();
  endtask

  task automatic rd_xfer(input logic [1:0] bank, input logic [9:0] a, input int n,
                         input string req);
    bit ak, all;
    all = 1'b1;
    bus_start();
    send_byte(AW, ak); all &= ak;
    send_byte({1'b0, 3'b000, bank, a[9:8]}, ak); all &= ak;
    send_byte(a[7:0], ak); all &= ak;
    bus_rstart();
    send_byte(AR, ak); all &= ak;
    chk(all, "R8 read setup acks", int'(all), 1);
    for (int i = 0; i < n; i++) recv_byte(i != n - 1, rbuf[i]);
    chk(sda_oe == 1'b0, "R8 release after decline", int'(sda_oe), 0);
    bus_stop();
  endtask

  task automatic t_reset();
    chk(sda_oe == 1'b0 && sda_line == 1'b1, "R1 reset idle", int'(sda_oe), 0);
  endtask

  task automatic t_addr_mismatch();
    bit ak;
    bus_start();
    send_byte(8'h26, ak);
    chk(!ak, "R2 foreign address nack", int'(ak), 0);
    send_byte(8'h00, ak);
    chk(!ak, "R2 later byte ignored", int'(ak), 0);
    bus_stop();
    bus_start();
    send_byte(AW, ak);
    chk(ak, "R2 own address ack", int'(ak), 1);
    bus_stop();
  endtask

  task automatic t_single_write();
    bit ok, pk;
    wbuf[0] = 8'hA5;
    wr_xfer(2'b01, 10'h123, 1'b0, 1, 0, 3'b000, 1'b1, ok, pk);
    chk(ok, "R3 control/address/data acks", int'(ok), 1);
    rd_xfer(2'b01, 10'h123, 1, "R7");
    chk(rbuf[0] == 8'hA5, "R7 single write stored", rbuf[0], 8'hA5);
  endtask

  task automatic t_bank_sep();
    bit ok, pk;
    wbuf[0] = 8'h3C;
    wr_xfer(2'b00, 10'h123, 1'b0, 1, 0, 3'b000, 1'b1, ok, pk);
    rd_xfer(2'b01, 10'h123, 1, "R4");
    chk(rbuf[0] == 8'hA5, "R4 RAM bank untouched", rbuf[0], 8'hA5);
    rd_xfer(2'b00, 10'h123, 1, "R4");
    chk(rbuf[0] == 8'h3C, "R4 nonvolatile bank value", rbuf[0], 8'h3C);
  endtask

  task automatic t_reserved();
    bit ak;
    for (int b = 2; b < 4; b++) begin
      bus_start();
      send_byte(AW, ak);
      send_byte({4'b0000, 2'(b), 2'b00}, ak);
      chk(!ak, "R4 reserved bank nack", int'(ak), 0);
      bus_stop();
    end
  endtask

  task automatic t_block_wrap();
    bit ok, pk;
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
    wr_xfer(2'b00, 10'h3FE, 1'b1, 4, 0, 3'b000, 1'b1, ok, pk);
    chk(ok, "R5 block write acks", int'(ok), 1);
    rd_xfer(2'b00, 10'h3FE, 4, "R7");
    for (int i = 0; i < 4; i++)
      chk(rbuf[i] == wbuf[i], "R7 wrapped block readback", rbuf[i], wbuf[i]);
    rd_xfer(2'b00, 10'h000, 2, "R8");
    chk(rbuf[0] == 8'h33 && rbuf[1] == 8'h44, "R8 read at wrapped address",
        {rbuf[0], rbuf[1]}, 16'h3344);
  endtask

  task automatic t_count_bad();
    bit ak;
    logic [7:0] cnts [2];
    cnts[0] = 8'd0; cnts[1] = 8'd9;
    for (int i = 0; i < 2; i++) begin
      bus_start();
      send_byte(AW, ak);
      send_byte(8'h80, ak);
      send_byte(8'h40, ak);
      send_byte(cnts[i], ak);
      chk(!ak, "R5 count out of range nack", int'(ak), 0);
      bus_stop();
    end
  endtask

  task automatic t_pec();
    bit ok, pk;
    wbuf[0] = 8'h5A; wbuf[1] = 8'hC3;
    wr_xfer(2'b01, 10'h010, 1'b1, 2, 1, 3'b000, 1'b1, ok, pk);
    chk(pk, "R6 good check byte ack", int'(pk), 1);
    rd_xfer(2'b01, 10'h010, 2, "R6");
    chk(rbuf[0] == 8'h5A && rbuf[1] == 8'hC3, "R6 checked write stored",
        {rbuf[0], rbuf[1]}, 16'h5AC3);
    wbuf[0] = 8'h01; wbuf[1] = 8'h02;
    wr_xfer(2'b01, 10'h010, 1'b1, 2, 2, 3'b000, 1'b1, ok, pk);
    chk(!pk, "R6 bad check byte nack", int'(pk), 0);
    rd_xfer(2'b01, 10'h010, 2, "R6");
    chk(rbuf[0] == 8'h5A && rbuf[1] == 8'hC3, "R6 bad check discards",
        {rbuf[0], rbuf[1]}, 16'h5AC3);
    wbuf[0] = 8'hE7;
    wr_xfer(2'b00, 10'h200, 1'b0, 1, 1, 3'b000, 1'b1, ok, pk);
    chk(pk, "R6 single byte with check ack", int'(pk), 1);
    rd_xfer(2'b00, 10'h200, 1, "R6");
    chk(rbuf[0] == 8'hE7, "R6 single byte stored", rbuf[0], 8'hE7);
  endtask

  task automatic t_ignored_bits();
    bit ok, pk;
    wbuf[0] = 8'h77;
    wr_xfer(2'b01, 10'h150, 1'b0, 1, 0, 3'b111, 1'b1, ok, pk);
    chk(ok, "R3 control bits 6:4 set still acked", int'(ok), 1);
    rd_xfer(2'b01, 10'h150, 1, "R3");
    chk(rbuf[0] == 8'h77, "R3 control bits 6:4 no effect", rbuf[0], 8'h77);
  endtask

  task automatic t_rstart();
    bit ok, pk, ak;
    logic [7:0] b;
    wbuf[0] = 8'h9E;
    wr_xfer(2'b01, 10'h060, 1'b0, 1, 0, 3'b000, 1'b0, ok, pk);
    bus_rstart();
    send_byte(AR, ak);
    chk(ak, "R9 address after repeated start", int'(ak), 1);
    recv_byte(1'b0, b);
    chk(b == 8'h9E, "R9 repeated start commits write", b, 8'h9E);
    bus_stop();
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin : main
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_addr_mismatch();
    t_single_write();
    t_bank_sep();
    t_reserved();
    t_block_wrap();
    t_count_bad();
    t_pec();
    t_ignored_bits();
    t_rstart();
    chk(viol == 0, "R10 drive changes only with clock low", viol, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule